// File: doc/BRIEF.md
# Reservation Tracker for Load-Reserve / Store-Conditional

This block sits beside a data cache and owns the one atomic-access reservation the cache keeps. A load-reserve request from the load/store path arms the reservation and records which cache line it covers. A later conditional store is compared against that reservation. On a match, the cache write and the memory bus cycle go ahead as for a plain store. On a miss, the block cancels the write, starts no bus transfer and reports the failure to writeback on the very next cycle.

The load/store path presents one request at a time with a valid bit, a two-bit operation code and a byte address. `req_ready_o` is high whenever the block can take a request. A store that goes to memory holds the block in a wait state until the memory acknowledges. Writeback sees a one-cycle completion pulse, a record-form flag (set for every conditional store) and a store-done flag (set when a store really reached memory).

Top module: `lrsc_tracker`

## Requirements
- R1: After reset no reservation exists, so a conditional store presented first fails. `req_ready_o` is 1 and `done_o` is 0.
- R2: A conditional store matches when the stored line address equals its address with the low 6 bits (64-byte line) dropped. The byte offset within the line never affects the match.
- R3: In the cycle a failing conditional store is accepted, `cancel_o` is 1 and both `cache_wr_o` and `bus_cyc_o` are 0.
- R4: A failing conditional store completes in the next cycle with `done_o`=1, `rc_o`=1 and `store_done_o`=0. `req_ready_o` stays 1 throughout, because no wait state is entered.
- R5: A matching conditional store drives `cache_wr_o` and `bus_cyc_o` to 1 and `cancel_o` to 0, then holds `req_ready_o` at 0 until `mem_ack_i`. One cycle after the ack it completes with `done_o`=1, `rc_o`=1 and `store_done_o`=1.
- R6: Every accepted conditional store, whether it passes or fails, clears the reservation.
- R7: A load-reserve sets the reservation and replaces any previously stored line with its own.
- R8: A plain store (op 2'b10) is never cancelled and leaves the reservation untouched. It completes one cycle after the ack with `rc_o`=0 and `store_done_o`=1.
- R9: A plain load (op 2'b00) or a load-reserve (op 2'b01) completes in the next cycle with `rc_o`=0 and `store_done_o`=0. A plain load leaves the reservation untouched. The operation codes are: 2'b00 load, 2'b01 load-reserve, 2'b10 store, 2'b11 conditional store.
- R10: `mem_ack_i` has no effect while no store is waiting.
- R11: A request presented while `req_ready_o` is 0 is ignored. It makes no cache write and no cancel, and it does not change the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Operation code (see R9) |
| req_addr_i | input | ADDR_W | Byte address |
| req_ready_o | output | 1 | Block idle and able to accept |
| cancel_o | output | 1 | Conditional store suppressed this cycle |
| cache_wr_o | output | 1 | Cache write permitted this cycle |
| bus_cyc_o | output | 1 | Start of a memory store cycle |
| mem_ack_i | input | 1 | Memory acknowledges the pending store |
| done_o | output | 1 | Completion pulse to writeback |
| rc_o | output | 1 | Record-form flag for the completing access |
| store_done_o | output | 1 | Store reached memory |

## Verification
A reservation bit that gets stuck, or a line tag that gets corrupted, shows up as a wrong `cancel_o` in the cycle the next conditional store is presented. The wrong `done_o`/`rc_o`/`store_done_o` pattern then follows one cycle after that, or one cycle after the ack if the store was wrongly allowed through. A wait state that is lost or held too long shows at once in `req_ready_o`. To expose these faults, the bench sweeps store addresses across line boundaries around each reserved address and issues a second conditional store after each one, which catches a reservation that was not cleared.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'b00,
    OP_LR = 2'b01,
    OP_ST = 2'b10,
    OP_SC = 2'b11
  } lsu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lrsc_state_e;

  typedef struct packed {
    logic done;
    logic rc;
    logic sd;
  } wb_info_t;
endpackage

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int ADDR_W    = 16,
  parameter int LINE_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - LINE_BITS;

  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tag_in;

  assign tag_in = addr_i[ADDR_W-1:LINE_BITS];
  assign hit_o  = vld_q && (tag_q == tag_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else if (set_i) begin
      vld_q <= 1'b1;
      tag_q <= tag_in;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_fsm.sv
module lrsc_fsm
  import lrsc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  lsu_op_e  op_i,
  input  logic     hit_i,
  input  logic     mem_ack_i,
  output logic     idle_o,
  output logic     cancel_o,
  output logic     store_go_o,
  output logic     resv_set_o,
  output logic     resv_clr_o,
  output wb_info_t fin_o
);
  lrsc_state_e state_q;
  logic        pend_sc_q;
  logic        accept, is_sc, sc_fail, fast, ack_fin;

  assign idle_o     = (state_q == ST_IDLE);
  assign accept     = req_valid_i && idle_o;
  assign is_sc      = (op_i == OP_SC);
  assign sc_fail    = accept && is_sc && !hit_i;
  assign store_go_o = accept && ((op_i == OP_ST) || (is_sc && hit_i));
  assign cancel_o   = sc_fail;
  assign resv_set_o = accept && (op_i == OP_LR);
  assign resv_clr_o = accept && is_sc;

  // loads and failed conditional stores finish without memory
  assign fast    = accept && ((op_i == OP_LD) || (op_i == OP_LR) || sc_fail);
  assign ack_fin = (state_q == ST_WAIT) && mem_ack_i;

  always_comb begin
    fin_o = '0;
    if (fast) begin
      fin_o.done = 1'b1;
      fin_o.rc   = is_sc;
    end else if (ack_fin) begin
      fin_o.done = 1'b1;
      fin_o.rc   = pend_sc_q;
      fin_o.sd   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_sc_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (store_go_o) begin
          state_q   <= ST_WAIT;
          pend_sc_q <= is_sc;
        end
        ST_WAIT: if (mem_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrsc_wb.sv
module lrsc_wb
  import lrsc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wb_info_t fin_i,
  output logic     done_o,
  output logic     rc_o,
  output logic     store_done_o
);
  wb_info_t wb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wb_q <= '0;
    else         wb_q <= fin_i;
  end

  assign done_o       = wb_q.done;
  assign rc_o         = wb_q.rc;
  assign store_done_o = wb_q.sd;
endmodule

// File: rtl/lrsc_tracker.sv
module lrsc_tracker
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              cancel_o,
  output logic              cache_wr_o,
  output logic              bus_cyc_o,
  input  logic              mem_ack_i,
  output logic              done_o,
  output logic              rc_o,
  output logic              store_done_o
);
  localparam int LINE_BITS = $clog2(LINE_BYTES);

  logic     hit, store_go, resv_set, resv_clr;
  wb_info_t fin;

  lrsc_resv #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_resv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (resv_set),
    .clr_i  (resv_clr),
    .addr_i (req_addr_i),
    .hit_o  (hit)
  );

  lrsc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .op_i       (lsu_op_e'(req_op_i)),
    .hit_i      (hit),
    .mem_ack_i  (mem_ack_i),
    .idle_o     (req_ready_o),
    .cancel_o   (cancel_o),
    .store_go_o (store_go),
    .resv_set_o (resv_set),
    .resv_clr_o (resv_clr),
    .fin_o      (fin)
  );

  assign cache_wr_o = store_go;
  assign bus_cyc_o  = store_go;

  lrsc_wb u_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fin_i       (fin),
    .done_o      (done_o),
    .rc_o        (rc_o),
    .store_done_o(store_done_o)
  );
endmodule

// File: rtl/lrsc_tracker_chk.sv
module lrsc_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] req_op_i,
  input logic       req_ready_o,
  input logic       cancel_o,
  input logic       cache_wr_o,
  input logic       bus_cyc_o,
  input logic       mem_ack_i,
  input logic       done_o,
  input logic       rc_o,
  input logic       store_done_o
);
  // R3
  cancel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> !cache_wr_o && !bus_cyc_o);
  // R4
  fail_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> done_o && rc_o && !store_done_o && req_ready_o);
  // R5
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |=> !req_ready_o);
  // R5
  sd_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_done_o |-> done_o && $past(mem_ack_i) && $past(!req_ready_o));
  // R8
  plain_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == 2'b10) |-> cache_wr_o && !cancel_o);
  // R9
  rc_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_o |-> done_o);
  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !cache_wr_o && !cancel_o);
endmodule

bind lrsc_tracker lrsc_tracker_chk u_chk (.*);

// File: tb/lrsc_tracker_tb.sv
`timescale 1ns/1ps
module lrsc_tracker_tb;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_op_i = 2'b00;
  logic [AW-1:0] req_addr_i = '0;
  logic          mem_ack_i = 1'b0;
  logic req_ready_o, cancel_o, cache_wr_o, bus_cyc_o, done_o, rc_o, store_done_o;

  int checks = 0;
  int errors = 0;

  lrsc_tracker #(.ADDR_W(AW), .LINE_BYTES(64)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one request; returns presentation-cycle outputs {ready,cancel,wr,bus}
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, output logic [3:0] pres);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a;
    #1 pres = {req_ready_o, cancel_o, cache_wr_o, bus_cyc_o};
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
  endtask

  task automatic ack;
    mem_ack_i = 1'b1;
    @(negedge clk_i);
    mem_ack_i = 1'b0;
    #1;
  endtask

  task automatic wb_chk(input string req, input logic [2:0] exp);
    chk(req, {done_o, rc_o, store_done_o}, exp);
  endtask

  // conditional store, checks outcome against expected match
  task automatic sc_run(input logic [AW-1:0] a, input logic exp_hit, input string req);
    logic [3:0] p;
    issue(2'b11, a, p);
    if (exp_hit) begin
      chk({req, " pass present"}, p, 4'b1011);
      chk({req, " wait ready"}, req_ready_o, 1'b0);
      wb_chk({req, " no early done"}, 3'b000);
      ack();
      wb_chk({req, " pass done"}, 3'b111);
    end else begin
      chk({req, " fail present"}, p, 4'b1100);
      wb_chk({req, " fail done"}, 3'b110);
      chk({req, " fail ready"}, req_ready_o, 1'b1);
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] p;
    #10 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1
    chk("R1 ready", req_ready_o, 1'b1);
    chk("R1 done", done_o, 1'b0);
    sc_run(12'h040, 1'b0, "R1 sc after reset");

    // R2 R6 sweep around reserved addresses
    for (int la = 0; la < 6; la++) begin
      logic [AW-1:0] a;
      a = AW'(la * 64 + 128 + ((la * 13) % 64));
      for (int k = 0; k < 20; k++) begin
        logic [AW-1:0] b;
        b = AW'(la * 64 + 64 + k * 7);
        issue(2'b01, a, p);
        wb_chk("R9 lr done", 3'b100);
        sc_run(b, (a[AW-1:6] == b[AW-1:6]), "R2 sweep");
        sc_run(a, 1'b0, "R6 cleared");
      end
    end

    // R7 replacement
    issue(2'b01, 12'h100, p);
    issue(2'b01, 12'h2c4, p);
    sc_run(12'h100, 1'b0, "R7 old line");
    issue(2'b01, 12'h100, p);
    issue(2'b01, 12'h2c4, p);
    sc_run(12'h2ff, 1'b1, "R7 new line");

    // R8 plain store: no reservation, not cancelled, reservation kept
    issue(2'b10, 12'h500, p);
    chk("R8 present", p, 4'b1011);
    ack();
    wb_chk("R8 done", 3'b101);
    issue(2'b01, 12'h500, p);
    issue(2'b10, 12'h500, p);
    ack();
    issue(2'b00, 12'h500, p);
    wb_chk("R9 load done", 3'b100);
    sc_run(12'h53c, 1'b1, "R8 R9 resv kept");

    // R10 stray ack
    @(negedge clk_i); #1;
    ack();
    wb_chk("R10 stray ack", 3'b000);
    chk("R10 ready", req_ready_o, 1'b1);

    // R11 requests during wait ignored
    issue(2'b01, 12'h700, p);
    issue(2'b11, 12'h700, p);
    chk("R11 setup", p, 4'b1011);
    issue(2'b01, 12'h700, p);
    chk("R11 busy present", p, 4'b0000);
    wb_chk("R11 busy no done", 3'b000);
    ack();
    wb_chk("R11 done once", 3'b111);
    @(negedge clk_i); #1;
    wb_chk("R11 single pulse", 3'b000);
    sc_run(12'h700, 1'b0, "R11 lr ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule